// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator

This block drives one pulse-width-modulated output from a two-stage count. A 6-bit prescaler stretches every counting tick to a programmable number of input clocks. A 10-bit period counter then steps through one waveform period in those ticks. The output is high for a programmable number of ticks at the start of each period. A separate full-duty flag holds the output high for the whole period, which the duty field by itself cannot express when the duty equals the period length.

Software reaches three registers over a small single-cycle bus: a control word holding the prescale and the stop style, a duty word, and a period word. The engine never uses these words directly. It copies them into its active settings only when it starts up and at each period boundary, so a write made in mid-period never shortens or splits a pulse. A run-enable input starts and stops the engine. When it drops, the engine either completes the period in progress or stops at once, as the control word selects.

Top module: `tick_pwm`

## Requirements
- R1: After reset, every register reads as zero and `pwm_out` is low.
- R2: Registers sit at byte offsets 0x0 (control: prescale in bits 5:0, immediate-stop select in bit 6), 0x4 (duty: high ticks in bits 9:0, full-duty flag in bit 10) and 0x8 (period: last tick index in bits 9:0). A read returns the last written value with all other bits zero. Any other offset reads as zero and ignores writes. `bus_rdata` is loaded on the clock edge that samples `bus_re` high and holds its value otherwise.
- R3: With prescale PS and period value PV, the waveform repeats every (PS+1)*(PV+1) input clocks, with one rising edge per period when the duty lies strictly between 0 and 100%.
- R4: With duty value DC and the full-duty flag clear, the output is high for DC*(PS+1) clocks per period. DC = 0 gives a constantly low output, and DC > PV gives a constantly high output.
- R5: With the full-duty flag set, the output stays high for the whole period, whatever DC is.
- R6: Register writes made while the engine runs reach the active settings only at a period boundary. The active settings change at no other time.
- R7: While `run_en` is low and the engine is idle, `pwm_out` stays low.
- R8: With immediate-stop clear, dropping `run_en` lets the period in progress finish, so a pulse already underway keeps its full length. The output then stays low.
- R9: With immediate-stop set, `pwm_out` is low from the first clock edge that samples `run_en` low.
- R10: Raising `run_en` again after a stop restarts the waveform with the register values written most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Engine run enable |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_re | input | 1 | Read strobe, single cycle |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Registered waveform output |

## Verification
The assertions assume that `run_en` and the bus strobes are synchronous to `clk`. They also assume that a change in the stop style takes effect on the next edge, because the stop decision reads the written control bit and not the active copy. The full-duty property holds only while no immediate stop is pending, so it excludes cycles where `run_en` is low with immediate-stop set. The bench drives every input on the falling edge and samples on the falling edge as well. It keeps random prescale and period values small, so that each measurement window spans whole periods. It reconfigures the block during a run only after a settling time longer than two old and two new periods.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;
  localparam int PRE_W    = 6;
  localparam int CNT_W    = 10;
  localparam int ADDR_W   = 4;
  localparam int HARD_BIT = 6;
  localparam int FULL_BIT = 10;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_DUTY = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_PER  = 4'h8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             full;
    logic [CNT_W-1:0] dc;
    logic [CNT_W-1:0] pv;
  } cfg_t;
endpackage

// File: rtl/tick_pwm_regs.sv
module tick_pwm_regs
  import tick_pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg_o,
  output logic              hard_o
);
  cfg_t              shadow;
  logic              hard_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      hard_q <= 1'b0;
    end else if (we) begin
      case (addr)
        OFS_CTRL: begin
          shadow.pre <= wdata[PRE_W-1:0];
          hard_q     <= wdata[HARD_BIT];
        end
        OFS_DUTY: begin
          shadow.dc   <= wdata[CNT_W-1:0];
          shadow.full <= wdata[FULL_BIT];
        end
        OFS_PER:  shadow.pv <= wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL: begin
        rd_mux[PRE_W-1:0] = shadow.pre;
        rd_mux[HARD_BIT]  = hard_q;
      end
      OFS_DUTY: begin
        rd_mux[CNT_W-1:0] = shadow.dc;
        rd_mux[FULL_BIT]  = shadow.full;
      end
      OFS_PER:  rd_mux[CNT_W-1:0] = shadow.pv;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end

  assign cfg_o  = shadow;
  assign hard_o = hard_q;
endmodule

// File: rtl/tick_pwm_prescale.sv
module tick_pwm_prescale #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [WIDTH-1:0] limit_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             tick_o
);
  logic [WIDTH-1:0] cnt;
  logic             at_limit;

  assign at_limit = (cnt == limit_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i)  cnt <= '0;
    else if (at_limit)  cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick_o = run_i && at_limit;
  assign cnt_o  = cnt;
endmodule

// File: rtl/tick_pwm_core.sv
module tick_pwm_core
  import tick_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             hard_i,
  input  cfg_t             shadow_i,
  input  logic             tick_i,
  output cfg_t             act_o,
  output logic             run_o,
  output logic [CNT_W-1:0] per_cnt_o,
  output logic             load_o,
  output logic             pwm_o
);
  cfg_t             act;
  logic             run;
  logic [CNT_W-1:0] per_cnt;
  logic             stop_now;
  logic             wrap;
  logic             level;

  assign stop_now = run && !run_en && hard_i;
  assign wrap     = run && tick_i && (per_cnt == act.pv);
  assign load_o   = (!run && run_en) || (!stop_now && wrap && run_en);
  assign level    = act.full || (per_cnt < act.dc);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      per_cnt <= '0;
      act     <= '0;
      pwm_o   <= 1'b0;
    end else begin
      if (!run) begin
        per_cnt <= '0;
        if (run_en) begin
          run <= 1'b1;
          act <= shadow_i;
        end
      end else if (stop_now) begin
        run     <= 1'b0;
        per_cnt <= '0;
      end else if (tick_i) begin
        if (per_cnt == act.pv) begin
          per_cnt <= '0;
          if (run_en) act <= shadow_i;
          else        run <= 1'b0;
        end else begin
          per_cnt <= per_cnt + 1'b1;
        end
      end
      pwm_o <= run && !stop_now && level;
    end
  end

  assign act_o     = act;
  assign run_o     = run;
  assign per_cnt_o = per_cnt;
endmodule

// File: rtl/tick_pwm.sv
module tick_pwm
  import tick_pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  cfg_t             shadow;
  cfg_t             act;
  logic             hard_sel;
  logic             run;
  logic             tick;
  logic             load;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] per_cnt;

  tick_pwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .we     (bus_we),
    .re     (bus_re),
    .rdata  (bus_rdata),
    .cfg_o  (shadow),
    .hard_o (hard_sel)
  );

  tick_pwm_prescale #(.WIDTH(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .limit_i (act.pre),
    .cnt_o   (pre_cnt),
    .tick_o  (tick)
  );

  tick_pwm_core u_core (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .hard_i    (hard_sel),
    .shadow_i  (shadow),
    .tick_i    (tick),
    .act_o     (act),
    .run_o     (run),
    .per_cnt_o (per_cnt),
    .load_o    (load),
    .pwm_o     (pwm_out)
  );
endmodule

// File: rtl/tick_pwm_chk.sv
module tick_pwm_chk
  import tick_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             hard_sel,
  input logic             run,
  input logic             load,
  input cfg_t             act,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] per_cnt,
  input logic             pwm_out
);
  assert_period_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (per_cnt <= act.pv));

  assert_tick_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre_cnt <= act.pre));

  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !act.full && act.dc == '0) |=> !pwm_out);

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
    (run && act.full && !(!run_en && hard_sel)) |=> pwm_out);

  assert_active_only_at_load_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act));

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_out);

  assert_hard_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_en && hard_sel) |=> !pwm_out);
endmodule

bind tick_pwm tick_pwm_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_en   (run_en),
  .hard_sel (hard_sel),
  .run      (run),
  .load     (load),
  .act      (act),
  .pre_cnt  (pre_cnt),
  .per_cnt  (per_cnt),
  .pwm_out  (pwm_out)
);

// File: tb/sim_tick_pwm.sv
`timescale 1ns/1ps
module sim_tick_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tick_pwm u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
  endtask

  task automatic setup(input int pre, input bit hard, input int pv, input int dc, input bit full);
    wr(4'h0, 32'(pre) | (32'(hard) << 6));
    wr(4'h4, 32'(dc) | (32'(full) << 10));
    wr(4'h8, 32'(pv));
  endtask

  function automatic int per_len(input int pre, input int pv);
    return (pre + 1) * (pv + 1);
  endfunction

  function automatic int high_len(input int pre, input int pv, input int dc, input bit full);
    if (full || dc > pv) return per_len(pre, pv);
    return dc * (pre + 1);
  endfunction

  task automatic measure(input int pre, input int pv, input int dc, input bit full, input string req);
    int p;
    int h;
    int hi;
    int rises;
    logic prev;
    p = per_len(pre, pv);
    h = high_len(pre, pv, dc, full);
    hi = 0;
    rises = 0;
    @(negedge clk);
    prev = pwm_out;
    for (int i = 0; i < 2 * p; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
    check(hi == 2 * h, {req, " high clocks in two periods"}, hi, 2 * h);
    check(rises == ((h > 0 && h < p) ? 2 : 0), "R3 rising edges in two periods",
          rises, (h > 0 && h < p) ? 2 : 0);
  endtask

  task automatic wait_rise(output bit seen);
    logic prev;
    seen = 1'b0;
    @(negedge clk);
    prev = pwm_out;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) seen = 1'b1;
      prev = pwm_out;
    end
  endtask

  initial begin
    int opre;
    int opv;
    int npre;
    int npv;
    int ndc;
    bit nfull;
    int lows;
    int hl;
    bit seen;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(pwm_out == 1'b0, "R1 output after reset", int'(pwm_out), 0);
    rd(4'h0, 32'h0, "R1 control after reset");
    rd(4'h4, 32'h0, "R1 duty after reset");
    rd(4'h8, 32'h0, "R1 period after reset");

    // R2: masking, unmapped offset
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0000_007F, "R2 control mask");
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, 32'h0000_07FF, "R2 duty mask");
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h0000_03FF, "R2 period mask");
    wr(4'hC, 32'h1234_5678);
    rd(4'hC, 32'h0, "R2 unmapped read");
    rd(4'h0, 32'h0000_007F, "R2 unmapped write ignored");
    @(negedge clk);
    check(bus_rdata == 32'h7F, "R2 read data holds without strobe", int'(bus_rdata), 32'h7F);

    // R7: idle with run_en low
    setup(0, 0, 3, 2, 0);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!pwm_out) lows++;
    end
    check(lows == 20, "R7 idle output low", lows, 20);

    // R3/R4 basic
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    measure(0, 3, 2, 0, "R4");

    // R4 corners: zero duty, duty beyond period, PV of zero
    setup(1, 0, 5, 0, 0);
    repeat (2 * 4 + 2 * 12 + 4) @(negedge clk);
    measure(1, 5, 0, 0, "R4 zero duty");
    setup(1, 0, 5, 9, 0);
    repeat (2 * 12 + 2 * 12 + 4) @(negedge clk);
    measure(1, 5, 9, 0, "R4 duty beyond period");
    setup(2, 0, 0, 1, 0);
    repeat (2 * 12 + 2 * 3 + 4) @(negedge clk);
    measure(2, 0, 1, 0, "R4 single tick period");

    // R5 full flag with small duty
    setup(1, 0, 6, 1, 1);
    repeat (2 * 3 + 2 * 14 + 4) @(negedge clk);
    measure(1, 6, 1, 1, "R5 full duty");

    // R6: random reconfiguration while running
    opre = 1;
    opv = 6;
    for (int k = 0; k < 10; k++) begin
      npre = $urandom % 4;
      npv = $urandom % 12;
      ndc = $urandom % 14;
      nfull = (($urandom % 5) == 0);
      setup(npre, 0, npv, ndc, nfull);
      repeat (2 * per_len(opre, opv) + 2 * per_len(npre, npv) + 4) @(negedge clk);
      measure(npre, npv, ndc, nfull, "R6 applied after boundary");
      opre = npre;
      opv = npv;
    end

    // R8: soft stop keeps the pulse whole
    setup(1, 0, 9, 4, 0);
    repeat (2 * per_len(opre, opv) + 2 * 20 + 4) @(negedge clk);
    wait_rise(seen);
    check(seen, "R8 rise seen before soft stop", int'(seen), 1);
    run_en = 1'b0;
    hl = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!pwm_out) break;
      hl++;
    end
    check(hl == 8, "R8 pulse length under soft stop", hl, 8);
    repeat (22) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!pwm_out) lows++;
    end
    check(lows == 30, "R8 output low after soft stop", lows, 30);

    // R10: restart picks up values written while stopped
    setup(0, 0, 4, 1, 0);
    run_en = 1'b1;
    repeat (6) @(negedge clk);
    measure(0, 4, 1, 0, "R10 restart");

    // R9: immediate stop
    setup(0, 1, 9, 5, 0);
    repeat (2 * 5 + 2 * 10 + 4) @(negedge clk);
    wait_rise(seen);
    check(seen, "R9 rise seen before hard stop", int'(seen), 1);
    run_en = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 output low one edge after stop", int'(pwm_out), 0);
    lows = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (!pwm_out) lows++;
    end
    check(lows == 25, "R9 output stays low", lows, 25);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule